// File: doc/BRIEF.md
# Circular Hit Memory With Readout Modes

This block buffers per-channel time codes in a circular dual-port store. Every channel delivers two 6-bit codes each clock, one for rising transitions and one for falling transitions. Bit 5 of each code is a hit tag and bits 4..0 are the fine-time value. While recording runs, the word made of all channel codes is written at the write pointer, and the pointer advances by one each clock, wrapping modulo the depth.

A read pointer selects the word presented at the outputs. Four readout modes are available:
- Mode 0 presents one word per clock, and every channel keeps its own tags.
- Mode 1 also presents one word per clock, but merges the tags into shared bits.
- Mode 2 reads all channels on each press of an external strobe.
- Mode 3 does the same but enables only one chosen channel.

The read pointer can follow the write pointer in lockstep, or step after each strobe release. The current read address travels with the data, and a one-clock strobe marks each fresh word.

Top module: `hit_ring_mem`

## Requirements
- R1: Synchronous reset (active high) clears both pointers, both run flags, all data outputs, `rptr_o`, `wr_strobe_o` and all enable flags to 0.
- R2: `wr_run_o` equals `wr_start_i` delayed by one clock. While it is high, the word {fall codes, rise codes} is written at the write pointer and the write pointer increments modulo 128 each clock.
- R3: While `wr_run_o` is high and `sync_inhibit_i` is 0, the read pointer increments every clock. With `sync_inhibit_i` at 1, that stepping does not happen.
- R4: `rd_run_o` equals (`rd_start_i` OR mode is 2 or 3) delayed one clock. In mode 0, every clock that `rd_run_o` is high loads the outputs with the word at the read pointer, loads `rptr_o` with that address, and pulses `wr_strobe_o` in the same clock.
- R5: Mode 1 (`rd_mode_i`=1) reads like mode 0, except for three tag bits. Channel 0's rising tag becomes the OR of all rising tags. Channel 0's falling tag becomes the OR of all falling tags. Channel 1's rising tag becomes the OR of all eight tags.
- R6: In modes 2 and 3, `rd_strobe_i` passes through a two-flop synchroniser. The outputs load on the detected rising edge, which appears three clocks after the input rises.
- R7: In modes 2 and 3, with `async_autoinc_i` at 1, the read pointer increments on the detected falling edge of the strobe. With `async_autoinc_i` at 0, it holds.
- R8: Enable flags are registered. `oe_n_i` at 1 clears all of them. In mode 3, only `ch_oe_o[ch_sel_i]` and `rptr_oe_o` are set. In the other modes, all flags are set.
- R9: With `zs_en_i` at 1, every clock without a read clears the output tag bits, so each tag is a one-clock pulse. With `zs_en_i` at 0, the tags hold like the data bits.
- R10: `ld_rptr_i` and `ld_wptr_i` load `ld_val_i` into the respective pointer. A load overrides any increment in the same clock.
- R11: A read and a write to the same address in the same clock return the previous content of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_start_i | input | 1 | Recording request (level) |
| rd_start_i | input | 1 | Synchronous readout request (level) |
| rise_code_i | input | NCH*6 | Rising-edge codes, channel i at bits 6i+5..6i |
| fall_code_i | input | NCH*6 | Falling-edge codes, same layout |
| rd_mode_i | input | 2 | Readout mode 0..3 |
| ch_sel_i | input | CHW | Channel chosen in mode 3 |
| oe_n_i | input | 1 | Output enable, active low |
| zs_en_i | input | 1 | Pulse-style hit tags |
| sync_inhibit_i | input | 1 | Stops lockstep read-pointer stepping |
| async_autoinc_i | input | 1 | Read pointer steps after strobe release |
| rd_strobe_i | input | 1 | Asynchronous read strobe |
| ld_rptr_i | input | 1 | Load read pointer |
| ld_wptr_i | input | 1 | Load write pointer |
| ld_val_i | input | AW | Pointer load value |
| rise_o | output | NCH*6 | Rising data out |
| fall_o | output | NCH*6 | Falling data out |
| rptr_o | output | AW | Address of presented word |
| ch_oe_o | output | NCH | Per-channel output enable flags |
| rptr_oe_o | output | 1 | Pointer output enable flag |
| wr_run_o | output | 1 | Recording active |
| rd_run_o | output | 1 | Readout active |
| wr_strobe_o | output | 1 | One-clock pulse marking fresh data |

## Verification
Writing and synchronous reading can hit the same word in the same clock. This happens when the read pointer runs in lockstep with the write pointer from a common start. The bench records more than one full lap, then enables mode 0 readout while recording continues, so that every clock both reads and overwrites one address. A behavioural model with its own memory array performs the read before the write each cycle. Its outputs must match the design's on every clock, so any read-after-write ordering, or an off-by-one between the pointers, shows up as a data mismatch.

// File: rtl/hm_pkg.sv
package hm_pkg;
  localparam int CODE_W  = 6;
  localparam int TAG_BIT = 5;

  typedef enum logic [1:0] {
    MODE_SYNC_CH   = 2'd0,
    MODE_SYNC_OR   = 2'd1,
    MODE_ASYNC_ALL = 2'd2,
    MODE_ASYNC_ONE = 2'd3
  } rd_mode_e;
endpackage

// File: rtl/hm_strobe_sync.sv
module hm_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q[0] <= strobe_i;
      last_q     <= chain_q[STAGES-1];
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= 1'b0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
  assign fall_o = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/hm_ptrs.sv
module hm_ptrs #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_run_i,
  input  logic          lockstep_en_i,
  input  logic          async_step_i,
  input  logic          ld_rptr_i,
  input  logic          ld_wptr_i,
  input  logic [AW-1:0] ld_val_i,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o
);
  always_ff @(posedge clk) begin
    if (rst)            wptr_o <= '0;
    else if (ld_wptr_i) wptr_o <= ld_val_i;
    else if (wr_run_i)  wptr_o <= wptr_o + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                             rptr_o <= '0;
    else if (ld_rptr_i)                  rptr_o <= ld_val_i;
    else if (async_step_i)               rptr_o <= rptr_o + 1'b1;
    else if (wr_run_i && lockstep_en_i)  rptr_o <= rptr_o + 1'b1;
  end

  p_wptr_step_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_run_i && !ld_wptr_i) |=> (wptr_o == AW'($past(wptr_o) + 1'b1)));

  p_wptr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr_run_i && !ld_wptr_i) |=> $stable(wptr_o));

  p_rptr_inhibit_r3: assert property (@(posedge clk) disable iff (rst)
    (!lockstep_en_i && !async_step_i && !ld_rptr_i) |=> $stable(rptr_o));

  p_rptr_load_r10: assert property (@(posedge clk) disable iff (rst)
    ld_rptr_i |=> (rptr_o == $past(ld_val_i)));
endmodule

// File: rtl/hm_store.sv
module hm_store #(
  parameter int AW    = 7,
  parameter int WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             re_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/hm_outctl.sv
module hm_outctl import hm_pkg::*; #(
  parameter int NCH = 4,
  parameter int AW  = 7,
  parameter int CHW = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_en_i,
  input  logic [1:0]              mode_i,
  input  logic [CHW-1:0]          ch_sel_i,
  input  logic                    oe_n_i,
  input  logic                    zs_en_i,
  input  logic [AW-1:0]           raddr_i,
  input  logic [2*NCH*CODE_W-1:0] rword_i,
  output logic [NCH*CODE_W-1:0]   rise_o,
  output logic [NCH*CODE_W-1:0]   fall_o,
  output logic [AW-1:0]           rptr_o,
  output logic [NCH-1:0]          ch_oe_o,
  output logic                    rptr_oe_o,
  output logic                    strobe_o
);
  localparam int SIDE_W = NCH * CODE_W;

  logic          merge_q;
  logic          tag_live_q;
  logic [NCH-1:0] rise_tags, fall_tags;
  logic [NCH-1:0] rise_sel, fall_sel;
  logic          rise_any, fall_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      merge_q    <= 1'b0;
      tag_live_q <= 1'b0;
      rptr_o     <= '0;
      strobe_o   <= 1'b0;
      rptr_oe_o  <= 1'b0;
    end else begin
      strobe_o  <= rd_en_i;
      rptr_oe_o <= ~oe_n_i;
      if (rd_en_i) begin
        merge_q    <= (mode_i == MODE_SYNC_OR);
        rptr_o     <= raddr_i;
        tag_live_q <= 1'b1;
      end else if (zs_en_i) begin
        tag_live_q <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) ch_oe_o[i] <= 1'b0;
      else     ch_oe_o[i] <= ~oe_n_i &&
                             ((mode_i != MODE_ASYNC_ONE) || (ch_sel_i == CHW'(i)));
    end

    assign rise_tags[i] = rword_i[i*CODE_W + TAG_BIT];
    assign fall_tags[i] = rword_i[SIDE_W + i*CODE_W + TAG_BIT];

    if (i == 0) begin : g_c0
      assign rise_sel[i] = merge_q ? rise_any : rise_tags[i];
      assign fall_sel[i] = merge_q ? fall_any : fall_tags[i];
    end else if (i == 1) begin : g_c1
      assign rise_sel[i] = merge_q ? (rise_any | fall_any) : rise_tags[i];
      assign fall_sel[i] = fall_tags[i];
    end else begin : g_cn
      assign rise_sel[i] = rise_tags[i];
      assign fall_sel[i] = fall_tags[i];
    end

    assign rise_o[i*CODE_W +: TAG_BIT] = rword_i[i*CODE_W +: TAG_BIT];
    assign fall_o[i*CODE_W +: TAG_BIT] = rword_i[SIDE_W + i*CODE_W +: TAG_BIT];
    assign rise_o[i*CODE_W + TAG_BIT]  = rise_sel[i] & tag_live_q;
    assign fall_o[i*CODE_W + TAG_BIT]  = fall_sel[i] & tag_live_q;
  end

  assign rise_any = |rise_tags;
  assign fall_any = |fall_tags;

  logic [2*NCH-1:0] out_tags;
  for (genvar i = 0; i < NCH; i++) begin : g_tagv
    assign out_tags[i]     = rise_o[i*CODE_W + TAG_BIT];
    assign out_tags[NCH+i] = fall_o[i*CODE_W + TAG_BIT];
  end

  p_zs_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (zs_en_i && !rd_en_i) |=> (out_tags == '0));

  p_oe_one_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MODE_ASYNC_ONE) |=> $onehot0(ch_oe_o));

  p_oe_off_r8: assert property (@(posedge clk) disable iff (rst)
    oe_n_i |=> ((ch_oe_o == '0) && !rptr_oe_o));
endmodule

// File: rtl/hit_ring_mem.sv
module hit_ring_mem import hm_pkg::*; #(
  parameter int NCH         = 4,
  parameter int AW          = 7,
  parameter int CHW         = $clog2(NCH),
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_start_i,
  input  logic                  rd_start_i,
  input  logic [NCH*CODE_W-1:0] rise_code_i,
  input  logic [NCH*CODE_W-1:0] fall_code_i,
  input  logic [1:0]            rd_mode_i,
  input  logic [CHW-1:0]        ch_sel_i,
  input  logic                  oe_n_i,
  input  logic                  zs_en_i,
  input  logic                  sync_inhibit_i,
  input  logic                  async_autoinc_i,
  input  logic                  rd_strobe_i,
  input  logic                  ld_rptr_i,
  input  logic                  ld_wptr_i,
  input  logic [AW-1:0]         ld_val_i,
  output logic [NCH*CODE_W-1:0] rise_o,
  output logic [NCH*CODE_W-1:0] fall_o,
  output logic [AW-1:0]         rptr_o,
  output logic [NCH-1:0]        ch_oe_o,
  output logic                  rptr_oe_o,
  output logic                  wr_run_o,
  output logic                  rd_run_o,
  output logic                  wr_strobe_o
);
  localparam int SIDE_W = NCH * CODE_W;
  localparam int WORD_W = 2 * SIDE_W;

  logic [AW-1:0]     wptr, rptr;
  logic              stb_rise, stb_fall;
  logic              async_mode, rd_en, async_step;
  logic [WORD_W-1:0] rword;

  assign async_mode = rd_mode_i[1];
  assign rd_en      = async_mode ? stb_rise : rd_run_o;
  assign async_step = async_mode & stb_fall & async_autoinc_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_run_o <= 1'b0;
      rd_run_o <= 1'b0;
    end else begin
      wr_run_o <= wr_start_i;
      rd_run_o <= rd_start_i | async_mode;
    end
  end

  hm_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .strobe_i(rd_strobe_i),
    .rise_o(stb_rise), .fall_o(stb_fall)
  );

  hm_ptrs #(.AW(AW)) u_ptrs (
    .clk(clk), .rst(rst), .wr_run_i(wr_run_o),
    .lockstep_en_i(~sync_inhibit_i), .async_step_i(async_step),
    .ld_rptr_i(ld_rptr_i), .ld_wptr_i(ld_wptr_i), .ld_val_i(ld_val_i),
    .wptr_o(wptr), .rptr_o(rptr)
  );

  hm_store #(.AW(AW), .WIDTH(WORD_W)) u_store (
    .clk(clk), .rst(rst), .we_i(wr_run_o), .waddr_i(wptr),
    .wdata_i({fall_code_i, rise_code_i}), .re_i(rd_en),
    .raddr_i(rptr), .rdata_o(rword)
  );

  hm_outctl #(.NCH(NCH), .AW(AW), .CHW(CHW)) u_out (
    .clk(clk), .rst(rst), .rd_en_i(rd_en), .mode_i(rd_mode_i),
    .ch_sel_i(ch_sel_i), .oe_n_i(oe_n_i), .zs_en_i(zs_en_i),
    .raddr_i(rptr), .rword_i(rword), .rise_o(rise_o), .fall_o(fall_o),
    .rptr_o(rptr_o), .ch_oe_o(ch_oe_o), .rptr_oe_o(rptr_oe_o),
    .strobe_o(wr_strobe_o)
  );

  p_async_no_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    (async_mode && !stb_rise) |=> !wr_strobe_o);
endmodule

// File: tb/sim_hit_ring_mem.sv
module sim_hit_ring_mem;
  localparam int NCH = 4;
  localparam int AW  = 7;
  localparam int SW  = NCH * 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_start = 0, rd_start = 0, oe_n = 1, zs_en = 0, inhib = 0, autoinc = 0;
  logic rd_strobe = 0, ld_rptr = 0, ld_wptr = 0;
  logic [AW-1:0] ld_val = '0;
  logic [1:0] rd_mode = 2'd0, ch_sel = 2'd0;
  logic [SW-1:0] rise_code = '0, fall_code = '0;
  logic [SW-1:0] rise_o, fall_o;
  logic [AW-1:0] rptr_o;
  logic [NCH-1:0] ch_oe;
  logic rptr_oe, wr_run, rd_run, wr_strobe;

  always #10 clk = ~clk;

  hit_ring_mem u0 (
    .clk(clk), .rst(rst), .wr_start_i(wr_start), .rd_start_i(rd_start),
    .rise_code_i(rise_code), .fall_code_i(fall_code), .rd_mode_i(rd_mode),
    .ch_sel_i(ch_sel), .oe_n_i(oe_n), .zs_en_i(zs_en), .sync_inhibit_i(inhib),
    .async_autoinc_i(autoinc), .rd_strobe_i(rd_strobe), .ld_rptr_i(ld_rptr),
    .ld_wptr_i(ld_wptr), .ld_val_i(ld_val), .rise_o(rise_o), .fall_o(fall_o),
    .rptr_o(rptr_o), .ch_oe_o(ch_oe), .rptr_oe_o(rptr_oe), .wr_run_o(wr_run),
    .rd_run_o(rd_run), .wr_strobe_o(wr_strobe)
  );

  // behavioural reference
  logic [2*SW-1:0] m_mem [128];
  logic [AW-1:0] m_wptr, m_rptr, m_rpo;
  logic [SW-1:0] m_rise, m_fall;
  logic [NCH-1:0] m_choe;
  logic m_rpoe, m_wrun, m_rrun, m_ws, ms1, ms2, ms3;

  always @(posedge clk) begin
    logic [2*SW-1:0] w;
    logic rdv, flv, rt, ft;
    if (rst) begin
      m_wptr = 0; m_rptr = 0; m_rpo = 0; m_rise = 0; m_fall = 0; m_choe = 0;
      m_rpoe = 0; m_wrun = 0; m_rrun = 0; m_ws = 0; ms1 = 0; ms2 = 0; ms3 = 0;
    end else begin
      rdv = rd_mode[1] ? (ms2 && !ms3) : m_rrun;
      flv = rd_mode[1] && !ms2 && ms3;
      m_ws = rdv;
      if (rdv) begin
        w = m_mem[m_rptr];
        rt = 0; ft = 0;
        for (int i = 0; i < NCH; i++) begin
          rt = rt | w[i*6+5];
          ft = ft | w[SW+i*6+5];
        end
        if (rd_mode == 2'd1) begin
          w[5] = rt; w[SW+5] = ft; w[11] = rt | ft;
        end
        m_rise = w[SW-1:0]; m_fall = w[2*SW-1:SW]; m_rpo = m_rptr;
      end else if (zs_en) begin
        for (int i = 0; i < NCH; i++) begin
          m_rise[i*6+5] = 0; m_fall[i*6+5] = 0;
        end
      end
      if (ld_rptr) m_rptr = ld_val;
      else if (flv && autoinc) m_rptr = m_rptr + 1;
      else if (m_wrun && !inhib) m_rptr = m_rptr + 1;
      if (m_wrun) m_mem[m_wptr] = {fall_code, rise_code};
      if (ld_wptr) m_wptr = ld_val;
      else if (m_wrun) m_wptr = m_wptr + 1;
      for (int i = 0; i < NCH; i++)
        m_choe[i] = !oe_n && (rd_mode != 2'd3 || ch_sel == 2'(i));
      m_rpoe = !oe_n;
      m_wrun = wr_start;
      m_rrun = rd_mode[1] | rd_start;
      ms3 = ms2; ms2 = ms1; ms1 = rd_strobe;
    end
  end

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  string cur_tag = "R2";

  task automatic chk(input string tag, input string what, input logic [63:0] got,
                     input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got=%h exp=%h at t=%0t", tag, what, got, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(cur_tag, "rise_o", 64'(rise_o), 64'(m_rise));
      chk(cur_tag, "fall_o", 64'(fall_o), 64'(m_fall));
      chk(cur_tag, "rptr_o", 64'(rptr_o), 64'(m_rpo));
      chk("R2", "wr_run", 64'(wr_run), 64'(m_wrun));
      chk("R4", "rd_run", 64'(rd_run), 64'(m_rrun));
      chk("R6", "wr_strobe", 64'(wr_strobe), 64'(m_ws));
      chk("R8", "ch_oe", 64'(ch_oe), 64'(m_choe));
      chk("R8", "rptr_oe", 64'(rptr_oe), 64'(m_rpoe));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(posedge clk); #2;
      rise_code = SW'($urandom);
      fall_code = SW'($urandom);
    end
  endtask

  task automatic strobe(input int hi, input int lo);
    rd_strobe = 1; cyc(hi);
    rd_strobe = 0; cyc(lo);
  endtask

  initial begin
    cyc(3);
    rst = 0;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "rise_o", 64'(rise_o), 64'd0);
    chk("R1", "fall_o", 64'(fall_o), 64'd0);
    chk("R1", "rptr_o", 64'(rptr_o), 64'd0);
    chk("R1", "flags", 64'({ch_oe, rptr_oe, wr_run, rd_run, wr_strobe}), 64'd0);
    // R2: record more than one lap
    cur_tag = "R2"; wr_start = 1; cyc(140);
    // R11 + R4: lockstep read of the word being overwritten
    cur_tag = "R11"; oe_n = 0; rd_start = 1; cyc(40);
    // R5: merged tags
    cur_tag = "R5"; rd_mode = 2'd1; cyc(30);
    // R3: lockstep inhibited
    cur_tag = "R3"; rd_mode = 2'd0; inhib = 1; cyc(12);
    // R10: pointer loads beat increments
    cur_tag = "R10"; ld_val = 7'd5; ld_rptr = 1; cyc(1);
    ld_rptr = 0; ld_val = 7'd100; ld_wptr = 1; cyc(1);
    ld_wptr = 0; inhib = 0; cyc(10);
    ld_val = 7'd127; ld_rptr = 1; cyc(1); ld_rptr = 0; cyc(6);
    // stop recording, switch to strobe readout
    wr_start = 0; rd_start = 0; cyc(4);
    cur_tag = "R7"; rd_mode = 2'd2; autoinc = 1; cyc(4);
    for (int k = 0; k < 6; k++) strobe(3, 4);
    cur_tag = "R9"; zs_en = 1;
    for (int k = 0; k < 5; k++) strobe(2, 5);
    zs_en = 0; strobe(2, 6);
    cur_tag = "R6"; rd_mode = 2'd3;
    for (int k = 0; k < 4; k++) begin
      ch_sel = 2'(k); strobe(4, 4);
    end
    autoinc = 0;
    for (int k = 0; k < 3; k++) strobe(1, 5);
    cur_tag = "R8"; oe_n = 1; strobe(3, 3); oe_n = 0; cyc(3);
    // R4: synchronous read while recording is stopped
    cur_tag = "R4"; rd_mode = 2'd0; rd_start = 1; cyc(10);
    rd_start = 0; zs_en = 1; cyc(5);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule